// File: doc/BRIEF.md
# Segmented Instruction Prefetch Unit

This block is the fetch front end of a 16-bit processor core. It keeps a 16-bit code segment and a 16-bit fetch offset. From the two it forms a 20-bit physical byte address, and it reads code one byte at a time through a 16-bit memory port. The port uses a request/grant handshake for the address and a separate response strobe for the data. Each byte that comes back goes into a small byte queue. A downstream execution stage drains that queue over a valid/ready handshake. Fetching carries on while the consumer stalls, so bytes can build up ahead of it.

A taken jump drives a one-cycle flush with a new segment:offset pair. The flush empties the queue and restarts fetching at the new place. A read that is still outstanding when the flush happens is marked stale, and its data is thrown away when it returns. When the queue is empty, an arriving byte passes straight to the consumer in the cycle it arrives.

Top module: `pf_prefetch_unit`

## Requirements
- R1: While reset is held, the segment is set to 0xFFFF, the offset to 0x0000 and the queue to empty. In the first cycle after reset, byte_valid_o is low, mem_req_o is high and mem_addr_o is 0xFFFF0.
- R2: mem_addr_o equals segment times 16 plus offset, taken modulo 2^20. For example, segment 0xFFFF with offset 0xFFFE gives 0x0FFEE.
- R3: Each granted request advances the offset by one, wrapping from 0xFFFF to 0x0000, and leaves the segment unchanged.
- R4: The byte is taken from the 16-bit read word by physical address bit 0. Bit 0 = 0 selects mem_rdata_i[7:0], and bit 0 = 1 selects mem_rdata_i[15:8].
- R5: An ungranted request stays asserted with a stable address until mem_gnt_i is seen, unless a flush intervenes.
- R6: At most one read is outstanding. No request is raised from a grant until the cycle after its response.
- R7: The queue holds 6 bytes. With the consumer stalled, exactly 6 reads are issued, and mem_req_o then stays low.
- R8: Bytes reach the consumer in fetch order, with none lost or repeated, including bytes that were buffered while the consumer stalled.
- R9: When the queue is empty, a byte that arrives with mem_rvalid_i shows on byte_data_o with byte_valid_o high in that same cycle.
- R10: In a cycle with flush_i high, mem_req_o and byte_valid_o are low. In the next cycle byte_valid_o is low, whatever the queue held before. Fetching then resumes at the new segment:offset.
- R11: The response to a read that was outstanding at a flush is dropped. The first byte delivered after the flush comes from the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Redirect strobe, one cycle |
| flush_seg_i | input | 16 | New code segment, loaded on flush |
| flush_off_i | input | 16 | New fetch offset, loaded on flush |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | 20 | Physical byte address of the request |
| mem_gnt_i | input | 1 | Request accepted this cycle |
| mem_rvalid_i | input | 1 | Read data returned this cycle |
| mem_rdata_i | input | 16 | Read word containing the addressed byte |
| byte_valid_o | output | 1 | A code byte is offered |
| byte_data_o | output | 8 | Offered code byte |
| byte_ready_i | input | 1 | Consumer takes the offered byte |

## Verification
The assertions assume a well-behaved memory port. It returns exactly one in-order response per grant, no earlier than the cycle after the grant. It never raises mem_rvalid_i when nothing is outstanding. A grant only counts while mem_req_o is high. The bench memory model grants only while the request is high and holds a single pending read with a chosen latency. It raises its response strobe only for that pending read. Flushes are driven as single-cycle pulses. Every input changes half a cycle away from the rising edge.

// File: rtl/pf_pkg.sv
package pf_pkg;

    // Status of the single outstanding memory read.
    typedef enum logic [1:0] {
        FETCH_IDLE  = 2'd0,   // nothing outstanding
        FETCH_WAIT  = 2'd1,   // read outstanding, data will be kept
        FETCH_STALE = 2'd2    // read outstanding, data will be dropped
    } fetch_state_e;

endpackage

// File: rtl/pf_addr_gen.sv
module pf_addr_gen #(
    parameter int SEG_W  = 16,
    parameter int OFF_W  = 16,
    parameter int ADDR_W = 20,
    parameter int SHIFT  = 4
) (
    input  logic [SEG_W-1:0]  seg_i,
    input  logic [OFF_W-1:0]  off_i,
    output logic [ADDR_W-1:0] phys_o
);

    logic [ADDR_W-1:0] seg_ext;
    logic [ADDR_W-1:0] off_ext;

    always_comb begin
        seg_ext = ADDR_W'(seg_i);
        off_ext = ADDR_W'(off_i);
        phys_o  = (seg_ext << SHIFT) + off_ext;   // carry beyond ADDR_W is dropped
    end

endmodule

// File: rtl/pf_fetch_ctrl.sv
module pf_fetch_ctrl
    import pf_pkg::*;
#(
    parameter int              SEG_W     = 16,
    parameter int              OFF_W     = 16,
    parameter int              LANE_W    = 1,
    parameter logic [SEG_W-1:0] RESET_SEG = '1,
    parameter logic [OFF_W-1:0] RESET_OFF = '0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              flush_i,
    input  logic [SEG_W-1:0]  flush_seg_i,
    input  logic [OFF_W-1:0]  flush_off_i,
    input  logic              room_i,
    input  logic [LANE_W-1:0] req_lane_i,
    input  logic              mem_gnt_i,
    input  logic              mem_rvalid_i,
    output logic              mem_req_o,
    output logic [SEG_W-1:0]  seg_o,
    output logic [OFF_W-1:0]  off_o,
    output logic [LANE_W-1:0] lane_o,
    output logic              push_o
);

    typedef struct packed {
        logic [SEG_W-1:0]  seg;
        logic [OFF_W-1:0]  off;
        logic [LANE_W-1:0] lane;
        fetch_state_e      st;
    } ctrl_t;

    ctrl_t state_q, state_d;

    always_comb begin
        state_d   = state_q;
        mem_req_o = !flush_i && (state_q.st == FETCH_IDLE) && room_i;
        push_o    = !flush_i && (state_q.st == FETCH_WAIT) && mem_rvalid_i;

        if (state_q.st != FETCH_IDLE && mem_rvalid_i) begin
            state_d.st = FETCH_IDLE;
        end
        if (mem_req_o && mem_gnt_i) begin
            state_d.st   = FETCH_WAIT;
            state_d.lane = req_lane_i;
            state_d.off  = state_q.off + OFF_W'(1);
        end
        if (flush_i) begin
            state_d.seg = flush_seg_i;
            state_d.off = flush_off_i;
            state_d.st  = (state_q.st != FETCH_IDLE && !mem_rvalid_i) ? FETCH_STALE
                                                                      : FETCH_IDLE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '{seg: RESET_SEG, off: RESET_OFF, lane: '0, st: FETCH_IDLE};
        end else begin
            state_q <= state_d;
        end
    end

    assign seg_o  = state_q.seg;
    assign off_o  = state_q.off;
    assign lane_o = state_q.lane;

    // A granted read advances the offset by exactly one.
    assert_ptr_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_o && mem_gnt_i && !flush_i) |=>
            (off_o == OFF_W'($past(off_o) + OFF_W'(1))) && $stable(seg_o));

    // An ungranted request is held with the same address.
    assert_req_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_o && !mem_gnt_i && !flush_i) |=>
            (flush_i || (mem_req_o && $stable(seg_o) && $stable(off_o))));

    // After a grant no second request follows in the next cycle.
    assert_one_outstanding_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_o && mem_gnt_i) |=> !mem_req_o);

    // A read cut off by a flush never reaches the queue.
    assert_stale_dropped_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flush_i && state_q.st != FETCH_IDLE && !mem_rvalid_i) |=> !push_o);

endmodule

// File: rtl/pf_byte_queue.sv
module pf_byte_queue #(
    parameter int DEPTH  = 6,
    parameter int BYTE_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clear_i,
    input  logic              push_i,
    input  logic [BYTE_W-1:0] push_data_i,
    input  logic              ready_i,
    output logic              valid_o,
    output logic [BYTE_W-1:0] data_o,
    output logic              room_o
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][BYTE_W-1:0] mem;
        logic [IDX_W-1:0]             rd;
        logic [IDX_W-1:0]             wr;
        logic [CNT_W-1:0]             cnt;
    } queue_t;

    queue_t state_q, state_d;
    logic   has_data, pop, store, take;

    function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(DEPTH - 1)) ? '0 : p + IDX_W'(1);
    endfunction

    always_comb begin
        state_d  = state_q;
        has_data = (state_q.cnt != '0);
        valid_o  = !clear_i && (has_data || push_i);
        data_o   = has_data ? state_q.mem[state_q.rd] : push_data_i;
        pop      = valid_o && ready_i;
        store    = push_i && !clear_i && (has_data || !ready_i);   // bypass skips storage
        take     = pop && has_data;
        room_o   = (state_q.cnt < CNT_W'(DEPTH));

        if (store) begin
            state_d.mem[state_q.wr] = push_data_i;
            state_d.wr              = step(state_q.wr);
        end
        if (take) begin
            state_d.rd = step(state_q.rd);
        end
        state_d.cnt = state_q.cnt + CNT_W'(store) - CNT_W'(take);

        if (clear_i) begin
            state_d.rd  = '0;
            state_d.wr  = '0;
            state_d.cnt = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && !clear_i) |-> (state_q.cnt < CNT_W'(DEPTH)));

    assert_count_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (store && take && !clear_i) |=> (state_q.cnt == $past(state_q.cnt)));

    assert_bypass_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && !clear_i && state_q.cnt == '0) |-> (valid_o && data_o == push_data_i));

    assert_flush_empties_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> (state_q.cnt == '0));

endmodule

// File: rtl/pf_prefetch_unit.sv
module pf_prefetch_unit #(
    parameter int               SEG_W     = 16,
    parameter int               OFF_W     = 16,
    parameter int               ADDR_W    = 20,
    parameter int               SEG_SHIFT = 4,
    parameter int               DATA_W    = 16,
    parameter int               BYTE_W    = 8,
    parameter int               QDEPTH    = 6,
    parameter logic [SEG_W-1:0] RESET_SEG = 16'hFFFF,
    parameter logic [OFF_W-1:0] RESET_OFF = 16'h0000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              flush_i,
    input  logic [SEG_W-1:0]  flush_seg_i,
    input  logic [OFF_W-1:0]  flush_off_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_gnt_i,
    input  logic              mem_rvalid_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              byte_valid_o,
    output logic [BYTE_W-1:0] byte_data_o,
    input  logic              byte_ready_i
);

    localparam int LANES  = DATA_W / BYTE_W;
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

    logic [SEG_W-1:0]              seg;
    logic [OFF_W-1:0]              off;
    logic [LANE_W-1:0]             lane;
    logic                          push;
    logic                          room;
    logic [LANES-1:0][BYTE_W-1:0]  lanes;
    logic [BYTE_W-1:0]             push_byte;

    pf_addr_gen #(
        .SEG_W (SEG_W),
        .OFF_W (OFF_W),
        .ADDR_W(ADDR_W),
        .SHIFT (SEG_SHIFT)
    ) i_addr (
        .seg_i (seg),
        .off_i (off),
        .phys_o(mem_addr_o)
    );

    pf_fetch_ctrl #(
        .SEG_W    (SEG_W),
        .OFF_W    (OFF_W),
        .LANE_W   (LANE_W),
        .RESET_SEG(RESET_SEG),
        .RESET_OFF(RESET_OFF)
    ) i_ctrl (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .flush_i     (flush_i),
        .flush_seg_i (flush_seg_i),
        .flush_off_i (flush_off_i),
        .room_i      (room),
        .req_lane_i  (mem_addr_o[LANE_W-1:0]),
        .mem_gnt_i   (mem_gnt_i),
        .mem_rvalid_i(mem_rvalid_i),
        .mem_req_o   (mem_req_o),
        .seg_o       (seg),
        .off_o       (off),
        .lane_o      (lane),
        .push_o      (push)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes[g] = mem_rdata_i[g*BYTE_W +: BYTE_W];
    end

    assign push_byte = lanes[lane];

    pf_byte_queue #(
        .DEPTH (QDEPTH),
        .BYTE_W(BYTE_W)
    ) i_queue (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clear_i    (flush_i),
        .push_i     (push),
        .push_data_i(push_byte),
        .ready_i    (byte_ready_i),
        .valid_o    (byte_valid_o),
        .data_o     (byte_data_o),
        .room_o     (room)
    );

endmodule

// File: tb/test_pf_prefetch_unit.sv
`timescale 1ns/1ps
module test_pf_prefetch_unit;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        flush_i = 1'b0;
    logic [15:0] flush_seg_i = '0;
    logic [15:0] flush_off_i = '0;
    logic        mem_req_o;
    logic [19:0] mem_addr_o;
    logic        mem_gnt_i = 1'b0;
    logic        mem_rvalid_i = 1'b0;
    logic [15:0] mem_rdata_i = '0;
    logic        byte_valid_o;
    logic [7:0]  byte_data_o;
    logic        byte_ready_i = 1'b0;

    int n_chk = 0;
    int n_err = 0;

    // memory model state
    bit          gnt_en = 1'b0;
    int          lat = 0;
    bit          pend = 1'b0;
    logic [19:0] pend_addr;
    int          wcnt = 0;
    logic [19:0] iss [64];
    int          n_iss = 0;
    int          viol = 0;
    // consumer log
    logic [7:0]  got [64];
    int          n_got = 0;

    pf_prefetch_unit i_pf_prefetch_unit (
        .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i),
        .flush_seg_i(flush_seg_i), .flush_off_i(flush_off_i),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_gnt_i(mem_gnt_i),
        .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
        .byte_valid_o(byte_valid_o), .byte_data_o(byte_data_o),
        .byte_ready_i(byte_ready_i)
    );

    initial forever #2 clk_i = ~clk_i;   // 250 MHz

    function automatic logic [7:0] mb(input logic [19:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ {4'h5, a[19:16]};
    endfunction

    function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
        int unsigned full;
        full = int'(s) * 16 + int'(o);
        return full[19:0];
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // memory responder: one pending read, response lat cycles after the grant cycle + 1
    initial forever begin
        @(negedge clk_i);
        #1;
        mem_gnt_i    = 1'b0;
        mem_rvalid_i = 1'b0;
        if (pend && mem_req_o) viol++;
        if (pend) begin
            if (wcnt == 0) begin
                mem_rvalid_i = 1'b1;
                mem_rdata_i  = {mb({pend_addr[19:1], 1'b1}), mb({pend_addr[19:1], 1'b0})};
                pend = 1'b0;
            end else begin
                wcnt--;
            end
        end
        if (mem_req_o && gnt_en && !pend) begin
            mem_gnt_i = 1'b1;
            pend      = 1'b1;
            pend_addr = mem_addr_o;
            wcnt      = lat;
            if (n_iss < 64) iss[n_iss] = mem_addr_o;
            n_iss++;
        end
    end

    // consumer: logs each byte taken at the coming edge
    initial forever begin
        @(negedge clk_i);
        #1.5;
        if (byte_valid_o && byte_ready_i) begin
            if (n_got < 64) got[n_got] = byte_data_o;
            n_got++;
        end
    end

    task automatic do_flush(input logic [15:0] s, input logic [15:0] o);
        @(negedge clk_i);
        flush_i = 1'b1; flush_seg_i = s; flush_off_i = o;
        n_iss = 0; n_got = 0;
        #1.5;
        chk("R10 req low during flush", int'(mem_req_o), 0);
        chk("R10 valid low during flush", int'(byte_valid_o), 0);
        @(negedge clk_i);
        flush_i = 1'b0;
    endtask

    task automatic wait_got(input int n);
        for (int i = 0; i < 400 && n_got < n; i++) @(negedge clk_i);
        chk("R8 byte count reached", int'(n_got >= n), 1);
    endtask

    task automatic t_reset;
        #1.5;
        chk("R1 valid low after reset", int'(byte_valid_o), 0);
        chk("R1 request after reset", int'(mem_req_o), 1);
        chk("R1 reset address", int'(mem_addr_o), 'hFFFF0);
    endtask

    task automatic t_hold;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk_i); #1.5;
            chk("R5 request held", int'(mem_req_o), 1);
            chk("R5 address stable", int'(mem_addr_o), 'hFFFF0);
        end
        gnt_en = 1'b1;
    endtask

    task automatic t_stream;
        lat = 0; byte_ready_i = 1'b1;
        do_flush(16'h1234, 16'h0005);
        wait_got(10);
        for (int k = 0; k < 10; k++) begin
            chk("R2 R3 issued address", int'(iss[k]), int'(phys(16'h1234, 16'(16'h0005 + k))));
            chk("R4 R8 byte in order", int'(got[k]), int'(mb(phys(16'h1234, 16'(16'h0005 + k)))));
        end
    endtask

    task automatic t_wrap;
        do_flush(16'hFFFF, 16'hFFFE);
        wait_got(3);
        chk("R2 truncated address", int'(iss[0]), 'h0FFEE);
        chk("R3 offset step", int'(iss[1]), 'h0FFEF);
        chk("R3 offset wrap", int'(iss[2]), 'hFFFF0);
        chk("R4 byte after wrap", int'(got[2]), int'(mb(20'hFFFF0)));
    endtask

    task automatic t_fill;
        byte_ready_i = 1'b0; lat = 0;
        do_flush(16'h0100, 16'h0000);
        repeat (40) @(negedge clk_i);
        #1.5;
        chk("R7 six reads when stalled", n_iss, 6);
        chk("R7 request stops when full", int'(mem_req_o), 0);
        chk("R8 byte waiting while stalled", int'(byte_valid_o), 1);
        @(negedge clk_i);
        byte_ready_i = 1'b1;
        wait_got(8);
        for (int k = 0; k < 8; k++)
            chk("R8 order after stall", int'(got[k]), int'(mb(phys(16'h0100, 16'(k)))));
    endtask

    task automatic t_bypass;
        bit seen = 1'b0;
        byte_ready_i = 1'b1; lat = 2;
        do_flush(16'h0200, 16'h0003);
        for (int i = 0; i < 20 && !seen; i++) begin
            @(negedge clk_i); #1.5;
            if (mem_rvalid_i) begin
                seen = 1'b1;
                chk("R9 valid with arrival", int'(byte_valid_o), 1);
                chk("R9 data with arrival", int'(byte_data_o), int'(mb(phys(16'h0200, 16'h0003))));
            end else begin
                chk("R9 no valid before arrival", int'(byte_valid_o), 0);
            end
        end
        chk("R9 arrival seen", int'(seen), 1);
    endtask

    task automatic t_single;
        byte_ready_i = 1'b1; lat = 3; viol = 0;
        do_flush(16'h0300, 16'h0000);
        wait_got(5);
        chk("R6 no request while outstanding", viol, 0);
        chk("R8 slow memory order", int'(got[4]), int'(mb(phys(16'h0300, 16'h0004))));
    endtask

    task automatic t_flush_drop;
        byte_ready_i = 1'b0; lat = 0;
        do_flush(16'h0400, 16'h0000);
        repeat (30) @(negedge clk_i);
        lat = 3;
        do_flush(16'h0500, 16'h0010);
        #1.5;
        chk("R10 full queue emptied", int'(byte_valid_o), 0);
        chk("R10 fetch resumes at new address", int'(mem_addr_o), int'(phys(16'h0500, 16'h0010)));
        do_flush(16'h0600, 16'h0020);
        #1.5;
        chk("R10 valid low after flush", int'(byte_valid_o), 0);
        byte_ready_i = 1'b1;
        wait_got(4);
        for (int k = 0; k < 4; k++)
            chk("R11 stale read dropped", int'(got[k]), int'(mb(phys(16'h0600, 16'(16'h0020 + k)))));
        chk("R6 no overlap across flush", viol, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk_i);
        rst_ni = 1'b1;
        t_reset();
        t_hold();
        t_stream();
        t_wrap();
        t_fill();
        t_bypass();
        t_single();
        t_flush_drop();
        repeat (3) @(negedge clk_i);
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk_i);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule